// File: doc/BRIEF.md
# DRAM Bank Page-Policy Sequencer

This block takes memory requests, each naming a bank, a row, a column and a direction. It turns them into DRAM commands at a rate of at most one per cycle. It keeps a small table with one entry per bank. Each entry records whether the bank holds an open row and, if so, which row. For each request the block issues only the commands that its bank state requires:

- an activate for an idle bank;
- a precharge followed by an activate when the bank holds a different row;
- only the column command when the row is already open.

A runtime input selects the page policy. Under the open-page policy, rows stay open after an access. Under the closed-page policy, the bank is precharged after every column command.

Minimum command spacings are enforced by per-bank countdown timers and by one shared column-gap timer. The spacings cover activate-to-column, precharge-to-activate, and column-to-column. The column-to-column gap is half the burst length, so the next column command can start while the current burst is still on the data bus. Three saturating counters classify the accepted requests as hits, misses to an idle bank, or conflicts with another open row.

Top module: `dramSeq`

## Requirements
- R1: A read or write command is issued only to a bank whose open row equals the request row; a request to an idle bank produces an activate (address field = row) followed by its column command.
- R2: A request to a bank holding a different row produces exactly precharge, activate, column command, in that order.
- R3: A request to a bank whose open row matches produces only the column command; each bank keeps its own open row, so requests alternating between open banks need no activate.
- R4: A column command to a bank comes no earlier than T_RCD cycles after its activate, and an activate comes no earlier than T_RP cycles after that bank's precharge.
- R5: Column commands are at least COL_GAP = BURST_LEN/2 cycles apart, and a hit that is waiting issues exactly COL_GAP cycles after the previous column command, overlapping the previous burst. No precharge comes within COL_GAP cycles of a column command.
- R6: With closedPage = 1, every column command is followed by a precharge to the same bank before any other command. The next access to that row is then a miss.
- R7: reqReady is high only in the cycle in which the column command for the held request is issued. The command code is 0 for activate, 1 for read, 2 for write and 3 for precharge. The address field carries the row for an activate and the column for a read or write.
- R8: Each accepted request increments exactly one counter: hitCount if no command preceded its column command, missCount if an activate did, and conflictCount if a precharge did. Each counter saturates at 2^CNT_W-1.
- R9: After reset no command is issued and all counters are zero; without a valid request or a pending precharge, cmdValid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| closedPage | input | 1 | 1 = precharge after every access, 0 = keep rows open |
| reqValid | input | 1 | Request present; held stable until accepted |
| reqReady | output | 1 | Request accepted (column command issued this cycle) |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Target column |
| reqWrite | input | 1 | 1 = write, 0 = read |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdCode | output | 2 | 0 ACT, 1 RD, 2 WR, 3 PRE |
| cmdBank | output | BANK_W | Bank of the command |
| cmdAddr | output | ADDR_W | Row (ACT), column (RD/WR), zero (PRE) |
| hitCount | output | CNT_W | Saturating row-hit count |
| missCount | output | CNT_W | Saturating idle-bank miss count |
| conflictCount | output | CNT_W | Saturating row-conflict count |

## Verification
The main table mixes several request patterns:

- first touches of idle banks, which must give activate then column;
- repeated rows, which must give a bare column command;
- alternation between two open banks, which tells per-bank row tracking apart from a single shared row;
- row changes within a bank, which must give the three-command conflict sequence.

A bench-side shadow of bank state checks every observed command against the spacing rules. Directed runs cover three further cases:

- two back-to-back hits to different banks, which tell the overlapping column issue apart from one that waits for the whole burst;
- the closed-page mode, where the next same-row request must become a miss;
- a long run of hits that drives the hit counter into saturation.

// File: rtl/dramSeqPkg.sv
package dramSeqPkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmdCode_e;

  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_MISS     = 2'd1,
    CLS_CONFLICT = 2'd2
  } reqClass_e;

  typedef struct packed {
    logic doAct;
    logic doPre;
    logic doCol;
    logic bumpHit;
    logic bumpMiss;
    logic bumpConflict;
  } seqStrobe_t;
endpackage

// File: rtl/dramSeqBankState.sv
module dramSeqBankState
  import dramSeqPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 2,
  parameter int COL_GAP   = 2,
  parameter int CNT_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int MAXT     = (T_RCD > T_RP) ? ((T_RCD > COL_GAP) ? T_RCD : COL_GAP)
                                           : ((T_RP > COL_GAP) ? T_RP : COL_GAP),
  localparam int TW       = $clog2(MAXT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [BANK_W-1:0] opBank,
  input  logic [ROW_W-1:0]  actRow,
  output logic              selOpen,
  output logic [ROW_W-1:0]  selRow,
  output logic              selTimerZero,
  output logic              gapZero,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic [CNT_W-1:0]  conflictCount
);
  localparam logic [TW-1:0] RCD_LOAD = TW'(T_RCD - 1);
  localparam logic [TW-1:0] RP_LOAD  = TW'(T_RP - 1);
  localparam logic [TW-1:0] GAP_LOAD = TW'(COL_GAP - 1);

  logic             openQ  [NUM_BANKS];
  logic [ROW_W-1:0] rowQ   [NUM_BANKS];
  logic [TW-1:0]    timerQ [NUM_BANKS];
  logic [TW-1:0]    gapQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ[b]  <= 1'b0;
        rowQ[b]   <= '0;
        timerQ[b] <= '0;
      end else if (stb.doAct && opBank == BANK_W'(b)) begin
        openQ[b]  <= 1'b1;
        rowQ[b]   <= actRow;
        timerQ[b] <= RCD_LOAD;
      end else if (stb.doPre && opBank == BANK_W'(b)) begin
        openQ[b]  <= 1'b0;
        timerQ[b] <= RP_LOAD;
      end else if (timerQ[b] != '0) begin
        timerQ[b] <= timerQ[b] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              gapQ <= '0;
    else if (stb.doCol)     gapQ <= GAP_LOAD;
    else if (gapQ != '0)    gapQ <= gapQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount      <= '0;
      missCount     <= '0;
      conflictCount <= '0;
    end else begin
      if (stb.bumpHit && hitCount != '1)           hitCount      <= hitCount + 1'b1;
      if (stb.bumpMiss && missCount != '1)         missCount     <= missCount + 1'b1;
      if (stb.bumpConflict && conflictCount != '1) conflictCount <= conflictCount + 1'b1;
    end
  end

  assign selOpen      = openQ[opBank];
  assign selRow       = rowQ[opBank];
  assign selTimerZero = (timerQ[opBank] == '0);
  assign gapZero      = (gapQ == '0);

  // R1: column commands only reach an open bank
  assert_col_open_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.doCol |-> openQ[opBank]);
  // R4: activate only on an idle bank whose precharge timer ran out
  assert_act_timing_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.doAct |-> (!openQ[opBank] && timerQ[opBank] == '0));
  // R5: column commands respect the burst gap
  assert_col_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.doCol |-> gapQ == '0);
  // R2: precharge only closes an open bank
  assert_pre_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.doPre |-> openQ[opBank]);
  // R8: one classification per accepted request
  assert_one_class_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.bumpHit, stb.bumpMiss, stb.bumpConflict}));
  // R8: counters never wrap
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(hitCount) == '1 |-> hitCount == '1);
endmodule

// File: rtl/dramSeqControl.sv
module dramSeqControl
  import dramSeqPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              closedPage,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  input  logic              selOpen,
  input  logic [ROW_W-1:0]  selRow,
  input  logic              selTimerZero,
  input  logic              gapZero,
  output seqStrobe_t        stb,
  output logic [BANK_W-1:0] opBank,
  output logic              cmdValid,
  output logic [1:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr
);
  logic              pendPreQ;
  logic [BANK_W-1:0] pendBankQ;
  reqClass_e         classQ;

  assign opBank = pendPreQ ? pendBankQ : reqBank;

  always_comb begin
    stb      = '0;
    cmdValid = 1'b0;
    cmdCode  = CMD_ACT;
    cmdAddr  = '0;
    reqReady = 1'b0;
    if (pendPreQ) begin
      if (gapZero && selTimerZero) begin
        stb.doPre = 1'b1;
        cmdValid  = 1'b1;
        cmdCode   = CMD_PRE;
      end
    end else if (reqValid) begin
      if (!selOpen) begin
        if (selTimerZero) begin
          stb.doAct = 1'b1;
          cmdValid  = 1'b1;
          cmdCode   = CMD_ACT;
          cmdAddr   = ADDR_W'(reqRow);
        end
      end else if (selRow != reqRow) begin
        if (selTimerZero && gapZero) begin
          stb.doPre = 1'b1;
          cmdValid  = 1'b1;
          cmdCode   = CMD_PRE;
        end
      end else if (selTimerZero && gapZero) begin
        stb.doCol        = 1'b1;
        cmdValid         = 1'b1;
        cmdCode          = reqWrite ? CMD_WR : CMD_RD;
        cmdAddr          = ADDR_W'(reqCol);
        reqReady         = 1'b1;
        stb.bumpHit      = (classQ == CLS_NONE);
        stb.bumpMiss     = (classQ == CLS_MISS);
        stb.bumpConflict = (classQ == CLS_CONFLICT);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPreQ  <= 1'b0;
      pendBankQ <= '0;
      classQ    <= CLS_NONE;
    end else begin
      if (stb.doCol) begin
        classQ    <= CLS_NONE;
        pendPreQ  <= closedPage;
        pendBankQ <= reqBank;
      end else if (stb.doPre && pendPreQ) begin
        pendPreQ <= 1'b0;
      end else if (stb.doPre) begin
        classQ <= CLS_CONFLICT;
      end else if (stb.doAct && classQ == CLS_NONE) begin
        classQ <= CLS_MISS;
      end
    end
  end

  // R6: a closed-page column command is followed by nothing but its precharge
  assert_closed_pre_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doCol && closedPage) |=> (!stb.doAct && !stb.doCol));
  // R7: acceptance coincides with a read or write command
  assert_accept_col_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (cmdValid && (cmdCode == CMD_RD || cmdCode == CMD_WR) && reqValid));
endmodule

// File: rtl/dramSeq.sv
module dramSeq
  import dramSeqPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 2,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int COL_GAP  = BURST_LEN / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              closedPage,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  output logic              cmdValid,
  output logic [1:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic [CNT_W-1:0]  conflictCount
);
  seqStrobe_t        stb;
  logic [BANK_W-1:0] opBank;
  logic              selOpen, selTimerZero, gapZero;
  logic [ROW_W-1:0]  selRow;

  dramSeqControl #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .closedPage(closedPage),
    .reqValid(reqValid), .reqReady(reqReady), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqWrite(reqWrite),
    .selOpen(selOpen), .selRow(selRow), .selTimerZero(selTimerZero),
    .gapZero(gapZero), .stb(stb), .opBank(opBank),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdAddr(cmdAddr)
  );

  dramSeqBankState #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .T_RCD(T_RCD),
                     .T_RP(T_RP), .COL_GAP(COL_GAP), .CNT_W(CNT_W)) state_i (
    .clk(clk), .rstN(rstN), .stb(stb), .opBank(opBank), .actRow(reqRow),
    .selOpen(selOpen), .selRow(selRow), .selTimerZero(selTimerZero),
    .gapZero(gapZero), .hitCount(hitCount), .missCount(missCount),
    .conflictCount(conflictCount)
  );

  assign cmdBank = opBank;
endmodule

// File: tb/dramSeq_tb_top.sv
module dramSeq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 3;
  localparam int T_RP = 2;
  localparam int COL_GAP = 2;

  typedef struct packed {
    logic [1:0] b;
    logic [7:0] r;
    logic [5:0] c;
    logic       w;
    logic [1:0] e;   // 0 hit, 1 miss, 2 conflict
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd0, 8'd5, 6'd1,  1'b0, 2'd1},
    '{2'd0, 8'd5, 6'd2,  1'b1, 2'd0},
    '{2'd1, 8'd7, 6'd3,  1'b0, 2'd1},
    '{2'd0, 8'd5, 6'd4,  1'b0, 2'd0},
    '{2'd1, 8'd7, 6'd5,  1'b1, 2'd0},
    '{2'd0, 8'd9, 6'd6,  1'b0, 2'd2},
    '{2'd0, 8'd9, 6'd7,  1'b1, 2'd0},
    '{2'd2, 8'd1, 6'd8,  1'b0, 2'd1},
    '{2'd3, 8'd1, 6'd9,  1'b1, 2'd1},
    '{2'd2, 8'd2, 6'd10, 1'b0, 2'd2},
    '{2'd3, 8'd1, 6'd11, 1'b0, 2'd0},
    '{2'd1, 8'd7, 6'd12, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic closedPage = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqBank = '0;
  logic [7:0] reqRow = '0;
  logic [5:0] reqCol = '0;
  logic reqWrite = 1'b0;
  logic cmdValid;
  logic [1:0] cmdCode;
  logic [1:0] cmdBank;
  logic [7:0] cmdAddr;
  logic [7:0] hitCount, missCount, conflictCount;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dramSeq dut_i (
    .clk(clk), .rstN(rstN), .closedPage(closedPage),
    .reqValid(reqValid), .reqReady(reqReady), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqWrite(reqWrite),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .hitCount(hitCount), .missCount(missCount),
    .conflictCount(conflictCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // shadow bank state built from observed commands
  int  cyc = 0;
  bit  shOpen [4];
  int  shRow  [4];
  int  actCyc [4];
  int  preCyc [4];
  int  lastColCyc = -100;
  int  prevColCyc = -100;
  int  seqN = 0;
  int  seqCode [8];
  int  lastPreBank = -1;

  initial for (int i = 0; i < 4; i++) begin
    shOpen[i] = 0; shRow[i] = -1; actCyc[i] = -100; preCyc[i] = -100;
  end

  always @(negedge clk) begin
    cyc++;
    if (rstN && cmdValid) begin
      if (seqN < 8) seqCode[seqN] = cmdCode;
      seqN++;
      case (cmdCode)
        2'd0: begin
          check(!shOpen[cmdBank], "R1 act to idle bank", shOpen[cmdBank], 0);
          check(cyc - preCyc[cmdBank] >= T_RP, "R4 tRP", cyc - preCyc[cmdBank], T_RP);
          check(cmdAddr == reqRow, "R7 act addr", cmdAddr, reqRow);
          shOpen[cmdBank] = 1; shRow[cmdBank] = cmdAddr; actCyc[cmdBank] = cyc;
        end
        2'd3: begin
          check(shOpen[cmdBank], "R2 pre to open bank", shOpen[cmdBank], 1);
          check(cyc - lastColCyc >= COL_GAP, "R5 pre after column", cyc - lastColCyc, COL_GAP);
          shOpen[cmdBank] = 0; preCyc[cmdBank] = cyc; lastPreBank = cmdBank;
        end
        default: begin
          check(shOpen[cmdBank] && shRow[cmdBank] == reqRow, "R1 column row open",
                shRow[cmdBank], reqRow);
          check(cyc - actCyc[cmdBank] >= T_RCD, "R4 tRCD", cyc - actCyc[cmdBank], T_RCD);
          check(cyc - lastColCyc >= COL_GAP, "R5 column gap", cyc - lastColCyc, COL_GAP);
          check(cmdCode == (reqWrite ? 2 : 1), "R7 column code", cmdCode, reqWrite ? 2 : 1);
          check(cmdAddr == reqCol && cmdBank == reqBank, "R7 column addr", cmdAddr, reqCol);
          check(reqReady, "R7 ready with column", reqReady, 1);
          prevColCyc = lastColCyc; lastColCyc = cyc;
        end
      endcase
    end
    if (rstN && reqReady)
      check(cmdValid && cmdCode inside {2'd1, 2'd2}, "R7 ready only on column", cmdCode, 1);
  end

  int expH = 0, expM = 0, expC = 0;

  task automatic doReq(input int b, input int r, input int c, input bit w,
                       input int expCls, input bit checkSeq);
    bit got;
    @(posedge clk); #1;
    reqBank = 2'(b); reqRow = 8'(r); reqCol = 6'(c); reqWrite = w; reqValid = 1'b1;
    seqN = 0;
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk);
      if (reqReady) got = 1;
    end
    check(got, "R7 request accepted", got, 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    if (checkSeq) begin
      case (expCls)
        0: begin
          check(seqN == 1, "R3 hit sequence length", seqN, 1);
        end
        1: begin
          check(seqN == 2 && seqCode[0] == 0, "R1 miss is ACT then column", seqN, 2);
        end
        default: begin
          check(seqN == 3 && seqCode[0] == 3 && seqCode[1] == 0,
                "R2 conflict is PRE, ACT, column", seqN, 3);
        end
      endcase
    end
    if (expCls == 0 && expH < 255) expH++;
    if (expCls == 1 && expM < 255) expM++;
    if (expCls == 2 && expC < 255) expC++;
    check(hitCount == 8'(expH), "R8 hit count", hitCount, expH);
    check(missCount == 8'(expM), "R8 miss count", missCount, expM);
    check(conflictCount == 8'(expC), "R8 conflict count", conflictCount, expC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state and idle behaviour
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!cmdValid, "R9 idle no command", cmdValid, 0);
      check(!reqReady, "R9 idle not ready", reqReady, 0);
    end
    check(hitCount == 0 && missCount == 0 && conflictCount == 0,
          "R9 counters zero after reset", hitCount + missCount + conflictCount, 0);

    // main table, open-page policy (R1, R2, R3, R8)
    for (int i = 0; i < 12; i++)
      doReq(VEC[i].b, VEC[i].r, VEC[i].c, VEC[i].w, VEC[i].e, 1'b1);

    // R5: overlapped column issue on back-to-back hits to two open banks
    doReq(2, 2, 20, 1'b0, 0, 1'b1);
    doReq(3, 1, 21, 1'b1, 0, 1'b1);
    check(lastColCyc - prevColCyc == COL_GAP, "R5 column overlap spacing",
          lastColCyc - prevColCyc, COL_GAP);

    // R6: closed-page policy
    closedPage = 1'b1;
    doReq(1, 7, 30, 1'b0, 0, 1'b1);
    repeat (6) @(negedge clk);
    check(!shOpen[1] && lastPreBank == 1, "R6 precharge after access", shOpen[1], 0);
    check(!cmdValid, "R9 no command when idle", cmdValid, 0);
    doReq(1, 7, 31, 1'b1, 1, 1'b1);
    repeat (6) @(negedge clk);
    check(!shOpen[1], "R6 bank closed again", shOpen[1], 0);
    doReq(1, 7, 32, 1'b0, 1, 1'b1);
    closedPage = 1'b0;
    repeat (6) @(negedge clk);

    // R8: hit counter saturation
    doReq(3, 1, 1, 1'b0, 0, 1'b1);
    for (int i = 0; i < 250; i++) doReq(3, 1, i % 64, i[0], 0, 1'b0);
    check(hitCount == 8'd255, "R8 hit counter saturates", hitCount, 255);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule